// File: doc/BRIEF.md
# Banked GPIO Controller with Line Interrupts

This block is a memory-mapped general-purpose I/O controller organised as a set of banks, each holding up to 32 lines. Software reaches it through a plain single-cycle register port. Each bank has eight 32-bit registers in a fixed 32-byte window. The registers select, per line, the driving direction, the output value, an open-drain style of driving and one of five interrupt triggers.

Pad inputs pass through a two-flop synchroniser. A one-cycle-delayed copy of the synchronised value is kept so that edges can be found. A detected trigger sets a sticky status bit, and software clears it by writing a one. A status bit that is also enabled in the mask register drives the single interrupt output, which is the OR of all enabled bits across every bank. A bank may be built narrower than 32 lines. Its missing positions read as zero, ignore writes and never raise status.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: Bank n occupies byte addresses n*32 to n*32+31. Address bits [4:2] pick the register: 0 open-drain enable, 1 data, 2 direction, 3 edge polarity, 4 any-edge, 5 mask, 6 level, 7 status. Address bits [1:0] are ignored, and a write reaches only the addressed bank.
- R2: After reset, every implemented direction bit reads 1 (input), the mask, status, level, polarity, any-edge, open-drain and data-out registers read 0, `pad_oe` is 0 and `irq` is 0.
- R3: For an implemented line, `pad_oe` is 1 exactly when its direction bit is 0 and either its open-drain bit is 0 or its data-out bit is 0. `pad_out` equals data-out AND NOT open-drain.
- R4: Reading the data register returns the synchronised pad value for lines whose direction bit is 1, and the written output value for lines whose direction bit is 0.
- R5: With level=1, a line sets status while its synchronised input is high if polarity=1, or while it is low if polarity=0.
- R6: With level=0 and any-edge=0, a line sets status on a rising edge if polarity=1, or on a falling edge if polarity=0.
- R7: With level=0 and any-edge=1, a line sets status on both edges, and the polarity bit has no effect.
- R8: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. A set status bit stays set until it is cleared.
- R9: When a detection and a clearing write hit the same bit in the same cycle, the bit ends up set. A level-mode bit cleared while its level still holds therefore reads 1 again straight after the write.
- R10: `irq` is the OR over all banks of status AND mask. A status bit still sets while its mask bit is 0.
- R11: Bit positions at or above a bank's configured width read 0 in every register, ignore writes and never set status.
- R12: A pad change that causes a detection is visible in status after the third rising clock edge following the change, and not after the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | ADDR_W | Byte address of the register access |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| pad_in | input | NUM_BANKS*32 | Pad input values, asynchronous |
| pad_out | output | NUM_BANKS*32 | Pad output values |
| pad_oe | output | NUM_BANKS*32 | Pad output enables, active high |
| irq | output | 1 | Shared interrupt request |

## Verification
The bench runs every one of the five trigger settings against all four before/after pad values on lines at both ends of a full bank and of a narrow bank. Two kinds of faulty design fail here. A design that swaps the polarity meaning, or that honours polarity in any-edge mode, sets status on the wrong transition. A design that forgets a status bit set by a level that held before the clear fails as well. The bench clears a level-mode bit while its level holds, to catch a design that lets the clear win and drops an asserted level. It clears single status bits, to catch a decoder that clears the whole register. It toggles a pad above a narrow bank's width, to catch a design that lets an unimplemented bit latch status or read back. It also counts synchroniser edges, so a missing or extra flop stage shows up as status appearing one cycle early or late.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  localparam int LINE_W        = 32;
  localparam int REGS_PER_BANK = 8;
  localparam int BANK_BYTES    = REGS_PER_BANK * 4;
  localparam int BANK_SHIFT    = $clog2(BANK_BYTES);
  localparam int WFIELD_W      = 6;

  typedef enum logic [2:0] {
    REG_ODRAIN  = 3'd0,
    REG_DATA    = 3'd1,
    REG_DIR     = 3'd2,
    REG_EPOL    = 3'd3,
    REG_ANYEDGE = 3'd4,
    REG_MASK    = 3'd5,
    REG_LEVEL   = 3'd6,
    REG_STATUS  = 3'd7
  } gpio_reg_e;

  function automatic logic [LINE_W-1:0] impl_mask(input int unsigned width);
    if (width >= LINE_W) return '1;
    return (LINE_W'(1) << width) - LINE_W'(1);
  endfunction

endpackage

// File: rtl/gpio_line_sync.sv
module gpio_line_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pad_i,
  output logic [W-1:0] cur_o,
  output logic [W-1:0] prev_o
);

  logic [W-1:0] meta_q;
  logic [W-1:0] cur_q;
  logic [W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      cur_q  <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= pad_i;
      cur_q  <= meta_q;
      prev_q <= cur_q;
    end
  end

  assign cur_o  = cur_q;
  assign prev_o = prev_q;

endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
  parameter int          W    = 32,
  parameter logic [W-1:0] IMPL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] cur_i,
  input  logic [W-1:0] prev_i,
  input  logic [W-1:0] level_i,
  input  logic [W-1:0] epol_i,
  input  logic [W-1:0] anyedge_i,
  input  logic         clr_we_i,
  input  logic [W-1:0] clr_data_i,
  output logic [W-1:0] status_o
);

  logic [W-1:0] rise;
  logic [W-1:0] fall;
  logic [W-1:0] toggled;
  logic [W-1:0] lvl_hit;
  logic [W-1:0] edge_hit;
  logic [W-1:0] hit;
  logic [W-1:0] clr_vec;
  logic [W-1:0] keep;
  logic [W-1:0] status_d;
  logic [W-1:0] status_q;

  always_comb begin
    rise     = cur_i & ~prev_i;
    fall     = ~cur_i & prev_i;
    toggled  = cur_i ^ prev_i;
    lvl_hit  = (epol_i & cur_i) | (~epol_i & ~cur_i);
    edge_hit = (anyedge_i & toggled) |
               (~anyedge_i & ((epol_i & rise) | (~epol_i & fall)));
    hit      = IMPL & ((level_i & lvl_hit) | (~level_i & edge_hit));
    clr_vec  = clr_we_i ? clr_data_i : '0;
    keep     = status_q & ~clr_vec;
    status_d = keep | hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= status_d;
  end

  assign status_o = status_q;

  // R8: a cleared bit with no fresh detection reads 0 afterwards
  p_w1c_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr_we_i |=> ((status_q & $past(clr_data_i & ~hit)) == '0));

  // R8: bits not being cleared stay set
  p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status_q & $past(keep)) == $past(keep)));

  // R9: a detection always lands, even against a clear
  p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (|hit) |=> ((status_q & $past(hit)) == $past(hit)));

endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter logic [LINE_W-1:0] IMPL = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  gpio_reg_e         reg_i,
  input  logic [LINE_W-1:0] wdata_i,
  output logic [LINE_W-1:0] rdata_o,
  input  logic [LINE_W-1:0] pad_in_i,
  output logic [LINE_W-1:0] pad_out_o,
  output logic [LINE_W-1:0] pad_oe_o,
  output logic              irq_o,
  output logic              mask_any_o
);

  logic [LINE_W-1:0] od_q, od_d;
  logic [LINE_W-1:0] dout_q, dout_d;
  logic [LINE_W-1:0] dir_q, dir_d;
  logic [LINE_W-1:0] epol_q, epol_d;
  logic [LINE_W-1:0] any_q, any_d;
  logic [LINE_W-1:0] mask_q, mask_d;
  logic [LINE_W-1:0] lvl_q, lvl_d;
  logic [LINE_W-1:0] wval;
  logic [LINE_W-1:0] cur;
  logic [LINE_W-1:0] prev;
  logic [LINE_W-1:0] status;
  logic              clr_we;

  assign wval   = wdata_i & IMPL;
  assign clr_we = wr_en_i && (reg_i == REG_STATUS);

  always_comb begin
    od_d   = od_q;
    dout_d = dout_q;
    dir_d  = dir_q;
    epol_d = epol_q;
    any_d  = any_q;
    mask_d = mask_q;
    lvl_d  = lvl_q;
    if (wr_en_i) begin
      case (reg_i)
        REG_ODRAIN:  od_d   = wval;
        REG_DATA:    dout_d = wval;
        REG_DIR:     dir_d  = wval;
        REG_EPOL:    epol_d = wval;
        REG_ANYEDGE: any_d  = wval;
        REG_MASK:    mask_d = wval;
        REG_LEVEL:   lvl_d  = wval;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      od_q   <= '0;
      dout_q <= '0;
      dir_q  <= IMPL;
      epol_q <= '0;
      any_q  <= '0;
      mask_q <= '0;
      lvl_q  <= '0;
    end else if (wr_en_i) begin
      od_q   <= od_d;
      dout_q <= dout_d;
      dir_q  <= dir_d;
      epol_q <= epol_d;
      any_q  <= any_d;
      mask_q <= mask_d;
      lvl_q  <= lvl_d;
    end
  end

  gpio_line_sync #(.W(LINE_W)) sync_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .pad_i  (pad_in_i),
    .cur_o  (cur),
    .prev_o (prev)
  );

  gpio_irq_detect #(.W(LINE_W), .IMPL(IMPL)) det_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .cur_i      (cur),
    .prev_i     (prev),
    .level_i    (lvl_q),
    .epol_i     (epol_q),
    .anyedge_i  (any_q),
    .clr_we_i   (clr_we),
    .clr_data_i (wval),
    .status_o   (status)
  );

  always_comb begin
    case (reg_i)
      REG_ODRAIN:  rdata_o = od_q;
      REG_DATA:    rdata_o = IMPL & ((dir_q & cur) | (~dir_q & dout_q));
      REG_DIR:     rdata_o = dir_q;
      REG_EPOL:    rdata_o = epol_q;
      REG_ANYEDGE: rdata_o = any_q;
      REG_MASK:    rdata_o = mask_q;
      REG_LEVEL:   rdata_o = lvl_q;
      default:     rdata_o = status;
    endcase
  end

  assign pad_oe_o   = IMPL & ~dir_q & (~od_q | ~dout_q);
  assign pad_out_o  = IMPL & dout_q & ~od_q;
  assign irq_o      = |(status & mask_q);
  assign mask_any_o = |mask_q;

  // R3: an open-drain line never drives a high value
  p_odrain_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_oe_o & pad_out_o & od_q) == '0));

endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
  import gpio_bank_pkg::*;
#(
  parameter  int                         NUM_BANKS   = 2,
  parameter  logic [NUM_BANKS*WFIELD_W-1:0] BANK_WIDTHS = {6'd5, 6'd8},
  localparam int                         ADDR_W      = $clog2(NUM_BANKS * BANK_BYTES)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [ADDR_W-1:0]           reg_addr,
  input  logic                        reg_wr,
  input  logic [LINE_W-1:0]           reg_wdata,
  output logic [LINE_W-1:0]           reg_rdata,
  input  logic [NUM_BANKS*LINE_W-1:0] pad_in,
  output logic [NUM_BANKS*LINE_W-1:0] pad_out,
  output logic [NUM_BANKS*LINE_W-1:0] pad_oe,
  output logic                        irq
);

  logic [LINE_W-1:0] bank_rdata [NUM_BANKS];
  logic [NUM_BANKS-1:0] bank_hit;
  logic [NUM_BANKS-1:0] bank_irq;
  logic [NUM_BANKS-1:0] bank_mask_any;
  gpio_reg_e            reg_sel;
  logic [1:0]           unused_byte_lane;

  assign reg_sel          = gpio_reg_e'(reg_addr[BANK_SHIFT-1:2]);
  assign unused_byte_lane = reg_addr[1:0];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam logic [LINE_W-1:0] IMPL =
      impl_mask(int'(BANK_WIDTHS[b*WFIELD_W +: WFIELD_W]));

    assign bank_hit[b] = ((32'(reg_addr) >> BANK_SHIFT) == 32'(b));

    gpio_bank #(.IMPL(IMPL)) bank_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en_i    (reg_wr && bank_hit[b]),
      .reg_i      (reg_sel),
      .wdata_i    (reg_wdata),
      .rdata_o    (bank_rdata[b]),
      .pad_in_i   (pad_in[b*LINE_W +: LINE_W]),
      .pad_out_o  (pad_out[b*LINE_W +: LINE_W]),
      .pad_oe_o   (pad_oe[b*LINE_W +: LINE_W]),
      .irq_o      (bank_irq[b]),
      .mask_any_o (bank_mask_any[b])
    );
  end

  always_comb begin
    reg_rdata = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (bank_hit[b]) reg_rdata = bank_rdata[b];
    end
  end

  assign irq = |bank_irq;

  // R10: no interrupt can be raised while every mask bit is clear
  p_irq_needs_mask_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (|bank_mask_any));

  // R1: at most one bank answers an address
  p_one_bank_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bank_hit));

endmodule

// File: tb/gpio_bank_ctrl_tb_top.sv
module gpio_bank_ctrl_tb_top;

  localparam logic [31:0] IMPL0 = 32'h0000_00FF;
  localparam logic [31:0] IMPL1 = 32'h0000_001F;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [63:0] pad_in = '0;
  logic [63:0] pad_out;
  logic [63:0] pad_oe;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  gpio_bank_ctrl dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .pad_in    (pad_in),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe),
    .irq       (irq)
  );

  function automatic int ra(input int bank, input int r);
    return bank * 32 + r * 4;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    reg_addr  = 6'(a);
    reg_wdata = d;
    reg_wr    = 1'b1;
    @(negedge clk);
    reg_wr    = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    reg_addr = 6'(a);
    #1;
    d = reg_rdata;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic zero_cfg();
    for (int b = 0; b < 2; b++) begin
      wr(ra(b, 6), '0);
      wr(ra(b, 3), '0);
      wr(ra(b, 4), '0);
      wr(ra(b, 5), '0);
    end
  endtask

  task automatic clear_all();
    wr(ra(0, 7), '1);
    wr(ra(1, 7), '1);
  endtask

  // Trigger sweep: R5 level, R6 single edge, R7 any edge
  task automatic run_sweep();
    int tb_bank [5] = '{0, 0, 0, 1, 1};
    int tb_line [5] = '{0, 3, 7, 0, 4};
    for (int t = 0; t < 5; t++) begin
      for (int m = 0; m < 5; m++) begin
        for (int ov = 0; ov < 2; ov++) begin
          for (int nv = 0; nv < 2; nv++) begin
            int          bk;
            int          pidx;
            logic [31:0] bv;
            logic [31:0] msk;
            logic [31:0] v;
            bit          lvl, pol, any, e;
            string       tag;
            bk   = tb_bank[t];
            pidx = bk * 32 + tb_line[t];
            bv   = 32'h1 << tb_line[t];
            case (m)
              0:       begin lvl = 1; pol = 1;     any = 0; tag = "R5"; e = (ov == 1) || (nv == 1); end
              1:       begin lvl = 1; pol = 0;     any = 0; tag = "R5"; e = (ov == 0) || (nv == 0); end
              2:       begin lvl = 0; pol = 1;     any = 0; tag = "R6"; e = (ov == 0) && (nv == 1); end
              3:       begin lvl = 0; pol = 0;     any = 0; tag = "R6"; e = (ov == 1) && (nv == 0); end
              default: begin lvl = 0; pol = nv[0]; any = 1; tag = "R7"; e = (ov != nv); end
            endcase
            msk = (((m + ov) % 2) == 1) ? bv : '0;
            zero_cfg();
            pad_in[pidx] = ov[0];
            settle();
            wr(ra(bk, 6), lvl ? bv : '0);
            wr(ra(bk, 3), pol ? bv : '0);
            wr(ra(bk, 4), any ? bv : '0);
            wr(ra(bk, 5), msk);
            clear_all();
            @(negedge clk);
            pad_in[pidx] = nv[0];
            settle();
            rd(ra(bk, 7), v);
            chk($sformatf("%s status bank%0d line%0d mode%0d %0d->%0d", tag, bk, tb_line[t], m, ov, nv),
                v, e ? bv : '0);
            chk($sformatf("R10 irq bank%0d line%0d mode%0d", bk, tb_line[t], m),
                {31'b0, irq}, {31'b0, e && (msk != '0)});
          end
        end
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [31:0] od, dout, dir, pin;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 reset state
    rd(ra(0, 2), v); chk("R2 dir bank0", v, IMPL0);
    rd(ra(1, 2), v); chk("R2 dir bank1", v, IMPL1);
    for (int b = 0; b < 2; b++) begin
      rd(ra(b, 5), v); chk("R2 mask", v, '0);
      rd(ra(b, 7), v); chk("R2 status", v, '0);
      rd(ra(b, 6), v); chk("R2 level", v, '0);
      rd(ra(b, 0), v); chk("R2 open-drain", v, '0);
    end
    chk("R2 irq", {31'b0, irq}, '0);
    chk("R2 pad_oe low", pad_oe[31:0], '0);
    chk("R2 pad_oe high", pad_oe[63:32], '0);

    // R1 bank isolation by address
    wr(ra(1, 5), 32'h0000_0011);
    rd(ra(0, 5), v); chk("R1 bank0 mask untouched", v, '0);
    rd(ra(1, 5) + 2, v); chk("R1 bank1 mask, low address bits ignored", v, 32'h11);
    wr(ra(1, 5), '0);

    // R3 / R4 pad driving and data readback
    od = 32'h0F; dout = 32'hA5; dir = 32'hF0; pin = 32'h3C;
    wr(ra(0, 0), od);
    wr(ra(0, 1), dout);
    wr(ra(0, 2), dir);
    pad_in[31:0] = pin;
    settle();
    chk("R3 pad_oe", pad_oe[31:0], IMPL0 & ~dir & (~od | ~dout));
    chk("R3 pad_out", pad_out[31:0], IMPL0 & dout & ~od);
    chk("R3 bank1 pad_oe", pad_oe[63:32], '0);
    rd(ra(0, 1), v); chk("R4 data readback", v, IMPL0 & ((dir & pin) | (~dir & dout)));
    wr(ra(0, 0), '0);
    chk("R3 push-pull pad_oe", pad_oe[31:0], IMPL0 & ~dir);
    wr(ra(0, 2), IMPL0);
    pad_in = '0;
    settle();

    // R11 unimplemented positions of bank1
    wr(ra(1, 2), '1);
    rd(ra(1, 2), v); chk("R11 dir width", v, IMPL1);
    wr(ra(1, 5), '1);
    rd(ra(1, 5), v); chk("R11 mask width", v, IMPL1);
    wr(ra(1, 4), '1);
    rd(ra(1, 4), v); chk("R11 any-edge width", v, IMPL1);
    clear_all();
    pad_in[40] = 1'b1; settle();
    rd(ra(1, 1), v); chk("R11 data bit8 reads zero", v, '0);
    pad_in[40] = 1'b0; settle();
    rd(ra(1, 7), v); chk("R11 status no set", v, '0);
    chk("R11 irq quiet", {31'b0, irq}, '0);

    // R12 latency
    zero_cfg();
    pad_in = '0; settle();
    wr(ra(0, 3), 32'h4);
    wr(ra(0, 5), 32'h4);
    clear_all();
    pad_in[2] = 1'b1;
    @(negedge clk); @(negedge clk);
    rd(ra(0, 7), v); chk("R12 not after second edge", v, '0);
    @(negedge clk);
    rd(ra(0, 7), v); chk("R12 set after third edge", v, 32'h4);
    chk("R12 irq", {31'b0, irq}, 32'h1);

    // R8 write-one-to-clear
    zero_cfg();
    pad_in = '0; settle();
    wr(ra(0, 4), 32'h3);
    clear_all();
    pad_in[1:0] = 2'b11; settle();
    rd(ra(0, 7), v); chk("R8 both set", v, 32'h3);
    wr(ra(0, 7), 32'h1);
    rd(ra(0, 7), v); chk("R8 clear bit0 only", v, 32'h2);
    wr(ra(0, 7), 32'h0);
    rd(ra(0, 7), v); chk("R8 zero write no effect", v, 32'h2);
    wr(ra(0, 7), 32'h2);
    rd(ra(0, 7), v); chk("R8 clear bit1", v, '0);

    // R9 level reasserts against a clear
    zero_cfg();
    pad_in = '0; settle();
    pad_in[5] = 1'b1; settle();
    wr(ra(0, 3), 32'h20);
    wr(ra(0, 6), 32'h20);
    wr(ra(0, 7), '1);
    rd(ra(0, 7), v); chk("R9 level set wins", v, 32'h20);
    pad_in[5] = 1'b0; settle();
    rd(ra(0, 7), v); chk("R8 sticky after level drops", v, 32'h20);
    wr(ra(0, 7), 32'h20);
    rd(ra(0, 7), v); chk("R9 cleared once level gone", v, '0);

    // R10 mask and cross-bank OR
    zero_cfg();
    pad_in = '0; settle();
    wr(ra(0, 4), 32'h1);
    wr(ra(1, 3), 32'h4);
    clear_all();
    pad_in[0] = 1'b1; settle();
    rd(ra(0, 7), v); chk("R10 status sets while masked", v, 32'h1);
    chk("R10 irq masked", {31'b0, irq}, '0);
    wr(ra(1, 5), 32'h4);
    pad_in[34] = 1'b1; settle();
    chk("R10 irq from bank1", {31'b0, irq}, 32'h1);
    wr(ra(1, 7), 32'h4);
    chk("R10 irq after bank1 clear", {31'b0, irq}, '0);
    wr(ra(0, 5), 32'h1);
    chk("R10 irq from bank0", {31'b0, irq}, 32'h1);
    pad_in = '0;

    run_sweep();

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule